// File: doc/BRIEF.md
# Variable-Pulse-Width Link Front-End Control

This block sits between the pins of a variable-pulse-width serial bus and the receive filter and transmit logic of its link controller. It chooses where the receive digital filter gets its input: from the bus receive pin, or, in loopback, from the controller's own transmitter output. In loopback it holds the transmit pin at the passive low level, so that a self-test never disturbs the bus. Loopback is meant for finding faults: if data looped through the digital path comes back intact, the fault lies in the physical layer.

When loopback is turned off, the block does not let the controller back onto the bus at once. Reception stays disabled until the bus has been idle for one end-of-frame time. Transmission stays disabled until the bus has been idle for one inter-frame separator time. The same guards apply after reset. The block also holds the bit-rate selection, normal (10.4 kbit/s) or four-times (41.6 kbit/s). A break symbol received at the fast rate drops the link back to normal speed and raises an invalid-symbol status code.

All pins are single-bit levels or strobes that are sampled on every clock. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `vpw_link_front`

## Requirements
- R1: With `loop_en` low, `filt_in` equals `rx_pin` and `tx_pin` equals `tx_data`, combinationally.
- R2: With `loop_en` high, `filt_in` equals `tx_data` and `tx_pin` is 0 whatever `tx_data` is.
- R3: Once `loop_en` has been low for a clock edge after being high, `rx_en` stays 0 until `rx_pin` has been sampled low (idle) on EOF_CYC consecutive clock edges at normal speed. `rx_en` rises in the cycle after the edge that takes the last of those samples.
- R4: Under the same conditions as R3, `tx_en` stays 0 until IFS_CYC consecutive idle samples have been taken. Both guards are sticky and stay met until loopback is set again or reset occurs.
- R5: A one-cycle pulse on `fast_wr` loads `fast_wdata` into the speed state, and the load shows on `rate_sel` in the next cycle (0 = 10.4 kbit/s, 1 = 41.6 kbit/s). A write also sets `stat_code` back to 8'h00.
- R6: A pulse on `brk_det` while `rate_sel` is 1 makes `rate_sel` 0 and `stat_code` 8'h1C in the next cycle. The code holds until the next speed write.
- R7: A pulse on `brk_det` while `rate_sel` is 0 changes neither `rate_sel` nor `stat_code`.
- R8: An active bus level (`rx_pin` = 1) sampled while a guard is still unmet restarts that guard's idle count from zero.
- R9: While `rate_sel` is 1, the guard thresholds are EOF_CYC/4 and IFS_CYC/4 idle samples, with a minimum of 1.
- R10: During and after reset, `rate_sel` is 0, `stat_code` is 8'h00, and `rx_en`/`tx_en` are 0 until their guards are first met.
- R11: While `loop_en` is high, `rx_en` and `tx_en` are both 1, and both guards are cleared.
- R12: If `brk_det` and `fast_wr` are pulsed in the same cycle while `rate_sel` is 1, the break wins: `rate_sel` becomes 0 and `stat_code` becomes 8'h1C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_en | input | 1 | Loopback control level |
| fast_wr | input | 1 | Speed write strobe |
| fast_wdata | input | 1 | Speed value written by `fast_wr` (1 = four-times rate) |
| brk_det | input | 1 | Break symbol detected strobe |
| rx_pin | input | 1 | Bus receive pin (1 = active) |
| tx_data | input | 1 | Transmitter output level |
| filt_in | output | 1 | Receive digital filter input |
| tx_pin | output | 1 | Bus transmit pin |
| rx_en | output | 1 | Reception allowed |
| tx_en | output | 1 | Transmission allowed |
| rate_sel | output | 1 | Bit rate select (0 = 10.4 kbit/s, 1 = 41.6 kbit/s) |
| stat_code | output | 8 | Status code (8'h00 none, 8'h1C invalid/out-of-range symbol) |

## Verification
Two functions can act on the speed state in the same cycle: the automatic drop to normal speed caused by a break, and a speed write. The bench pulses `brk_det` and `fast_wr` together while the fast rate is active and expects the break to take priority. It also sets up a guard that is one idle sample short of its threshold and then changes the speed in that cycle. The threshold in force is the one for the speed held before the edge, and the per-cycle reference model applies the same rule to decide which cycle the enable rises in.

// File: rtl/vpw_front_pkg.sv
package vpw_front_pkg;

  typedef enum logic [7:0] {
    ST_NONE    = 8'h00,
    ST_BAD_SYM = 8'h1C
  } vpw_stat_e;

  function automatic int quarter_min1(input int n);
    return (n / 4 < 1) ? 1 : n / 4;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/vpw_route_mux.sv
module vpw_route_mux (
  input  logic loop_en,
  input  logic rx_pin,
  input  logic tx_data,
  output logic filt_in,
  output logic tx_pin
);

  always_comb begin
    if (loop_en) begin
      filt_in = tx_data;
      tx_pin  = 1'b0;
    end else begin
      filt_in = rx_pin;
      tx_pin  = tx_data;
    end
  end

endmodule

// File: rtl/vpw_idle_guard.sv
module vpw_idle_guard #(
  parameter int NORM_CYC = 40,
  parameter int FAST_CYC = 10,
  parameter int CW       = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic fast,
  input  logic bus_active,
  output logic met
);

  localparam logic [CW-1:0] THR_N = CW'(NORM_CYC);
  localparam logic [CW-1:0] THR_F = CW'(FAST_CYC);

  logic [CW-1:0] cnt;
  logic [CW-1:0] thr;
  logic [CW-1:0] cnt_nx;

  assign thr    = fast ? THR_F : THR_N;
  assign cnt_nx = cnt + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      met <= 1'b0;
    end else if (hold) begin
      cnt <= '0;
      met <= 1'b0;
    end else if (!met) begin
      if (bus_active) begin
        cnt <= '0;
      end else if (cnt_nx >= thr) begin
        cnt <= '0;
        met <= 1'b1;
      end else begin
        cnt <= cnt_nx;
      end
    end
  end

endmodule

// File: rtl/vpw_speed_ctl.sv
module vpw_speed_ctl
  import vpw_front_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic       wdata,
  input  logic       brk,
  output logic       fast,
  output vpw_stat_e  stat
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast <= 1'b0;
      stat <= ST_NONE;
    end else if (brk && fast) begin
      fast <= 1'b0;
      stat <= ST_BAD_SYM;
    end else if (wr) begin
      fast <= wdata;
      stat <= ST_NONE;
    end
  end

endmodule

// File: rtl/vpw_link_front.sv
module vpw_link_front
  import vpw_front_pkg::*;
#(
  parameter int EOF_CYC = 40,
  parameter int IFS_CYC = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       loop_en,
  input  logic       fast_wr,
  input  logic       fast_wdata,
  input  logic       brk_det,
  input  logic       rx_pin,
  input  logic       tx_data,
  output logic       filt_in,
  output logic       tx_pin,
  output logic       rx_en,
  output logic       tx_en,
  output logic       rate_sel,
  output logic [7:0] stat_code
);

  localparam int NGUARD = 2;
  localparam int CW     = $clog2(max_int(EOF_CYC, IFS_CYC) + 1);

  logic [NGUARD-1:0] met;
  logic              fast;
  vpw_stat_e         stat;

  vpw_route_mux u_route (
    .loop_en (loop_en),
    .rx_pin  (rx_pin),
    .tx_data (tx_data),
    .filt_in (filt_in),
    .tx_pin  (tx_pin)
  );

  vpw_speed_ctl u_speed (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (fast_wr),
    .wdata (fast_wdata),
    .brk   (brk_det),
    .fast  (fast),
    .stat  (stat)
  );

  // guard 0: end-of-frame idle (receive), guard 1: inter-frame idle (transmit)
  for (genvar gi = 0; gi < NGUARD; gi++) begin : g_guard
    localparam int NCYC = (gi == 0) ? EOF_CYC : IFS_CYC;
    vpw_idle_guard #(
      .NORM_CYC (NCYC),
      .FAST_CYC (quarter_min1(NCYC)),
      .CW       (CW)
    ) u_guard (
      .clk        (clk),
      .rst_n      (rst_n),
      .hold       (loop_en),
      .fast       (fast),
      .bus_active (rx_pin),
      .met        (met[gi])
    );
  end

  assign rx_en     = loop_en | met[0];
  assign tx_en     = loop_en | met[1];
  assign rate_sel  = fast;
  assign stat_code = stat;

endmodule

// File: rtl/vpw_link_front_chk.sv
module vpw_link_front_chk #(
  parameter int EOF_CYC = 40,
  parameter int IFS_CYC = 60
) (
  input logic       clk,
  input logic       rst_n,
  input logic       loop_en,
  input logic       fast_wr,
  input logic       fast_wdata,
  input logic       brk_det,
  input logic       rx_pin,
  input logic       tx_data,
  input logic       filt_in,
  input logic       tx_pin,
  input logic       rx_en,
  input logic       tx_en,
  input logic       rate_sel,
  input logic [7:0] stat_code
);

  p_route_norm_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |-> (filt_in == rx_pin) && (tx_pin == tx_data));

  p_route_loop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (filt_in == tx_data) && !tx_pin);

  p_guard_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(loop_en) |-> !rx_en && !tx_en);

  p_loop_enables_r11: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> rx_en && tx_en);

  p_idle_before_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en && $past(!loop_en) && $rose(rx_en) |-> $past(!rx_pin));

  p_idle_before_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en && $past(!loop_en) && $rose(tx_en) |-> $past(!rx_pin));

  p_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fast_wr && !(brk_det && rate_sel) |=> (rate_sel == $past(fast_wdata)) && (stat_code == 8'h00));

  p_break_fast_r6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_det && rate_sel |=> !rate_sel && (stat_code == 8'h1C));

  p_break_norm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_det && !rate_sel && !fast_wr |=> !rate_sel && $stable(stat_code));

  p_hold_speed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !brk_det && !fast_wr |=> $stable(rate_sel) && $stable(stat_code));

  p_stat_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_code == 8'h00) || (stat_code == 8'h1C));

endmodule

bind vpw_link_front vpw_link_front_chk #(.EOF_CYC(EOF_CYC), .IFS_CYC(IFS_CYC)) i_chk (.*);

// File: tb/test_vpw_link_front.sv
module test_vpw_link_front;

  localparam int CLK_PERIOD = 10;
  localparam int EOF_CYC    = 40;
  localparam int IFS_CYC    = 60;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       loop_en = 1'b0, fast_wr = 1'b0, fast_wdata = 1'b0, brk_det = 1'b0;
  logic       rx_pin = 1'b0, tx_data = 1'b0;
  logic       filt_in, tx_pin, rx_en, tx_en, rate_sel;
  logic [7:0] stat_code;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  vpw_link_front #(.EOF_CYC(EOF_CYC), .IFS_CYC(IFS_CYC)) i_vpw_link_front (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .fast_wr(fast_wr),
    .fast_wdata(fast_wdata), .brk_det(brk_det), .rx_pin(rx_pin), .tx_data(tx_data),
    .filt_in(filt_in), .tx_pin(tx_pin), .rx_en(rx_en), .tx_en(tx_en),
    .rate_sel(rate_sel), .stat_code(stat_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int  m_cnt_e = 0, m_cnt_i = 0;
  bit  m_met_e = 0, m_met_i = 0, m_fast = 0;
  int  m_stat = 0;

  always @(posedge clk) begin
    int te, ti;
    if (!rst_n) begin
      m_cnt_e = 0; m_cnt_i = 0; m_met_e = 0; m_met_i = 0; m_fast = 0; m_stat = 0;
    end else begin
      te = m_fast ? ((EOF_CYC/4 < 1) ? 1 : EOF_CYC/4) : EOF_CYC;
      ti = m_fast ? ((IFS_CYC/4 < 1) ? 1 : IFS_CYC/4) : IFS_CYC;
      if (loop_en) begin
        m_cnt_e = 0; m_cnt_i = 0; m_met_e = 0; m_met_i = 0;
      end else begin
        if (!m_met_e) begin
          if (rx_pin) m_cnt_e = 0;
          else if (m_cnt_e + 1 >= te) begin m_met_e = 1; m_cnt_e = 0; end
          else m_cnt_e++;
        end
        if (!m_met_i) begin
          if (rx_pin) m_cnt_i = 0;
          else if (m_cnt_i + 1 >= ti) begin m_met_i = 1; m_cnt_i = 0; end
          else m_cnt_i++;
        end
      end
      if (brk_det && m_fast) begin m_fast = 0; m_stat = 'h1C; end
      else if (fast_wr) begin m_fast = fast_wdata; m_stat = 0; end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(filt_in == (loop_en ? tx_data : rx_pin), loop_en ? "R2 filt_in" : "R1 filt_in",
          filt_in, loop_en ? tx_data : rx_pin);
      chk(tx_pin == (loop_en ? 1'b0 : tx_data), loop_en ? "R2 tx_pin" : "R1 tx_pin",
          tx_pin, loop_en ? 0 : tx_data);
      chk(rx_en == (loop_en | m_met_e), "R3/R8/R9/R11 rx_en", rx_en, loop_en | m_met_e);
      chk(tx_en == (loop_en | m_met_i), "R4/R8/R9/R11 tx_en", tx_en, loop_en | m_met_i);
      chk(rate_sel == m_fast, "R5/R6/R7 rate_sel", rate_sel, m_fast);
      chk(stat_code == m_stat[7:0], "R6/R7/R12 stat_code", stat_code, m_stat);
    end
  end

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic speed_write(input bit v);
    fast_wr = 1'b1; fast_wdata = v; tick(1); fast_wr = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(3);
    // R10: reset values
    chk(rate_sel == 0, "R10 rate_sel", rate_sel, 0);
    chk(stat_code == 0, "R10 stat_code", stat_code, 0);
    chk(!rx_en && !tx_en, "R10 enables", {rx_en, tx_en}, 0);
    rst_n = 1'b1;
    tick(EOF_CYC - 1);
    chk(!rx_en, "R10 rx_en before guard", rx_en, 0);
    tick(1);
    chk(rx_en && !tx_en, "R3 rx_en at EOF", {rx_en, tx_en}, 2);
    tick(IFS_CYC - EOF_CYC);
    chk(tx_en, "R4 tx_en at IFS", tx_en, 1);
    // R1 routing with patterns
    for (int k = 0; k < 16; k++) begin
      tx_data = k[0]; rx_pin = k[1]; tick(1);
    end
    rx_pin = 0;
    // R2/R11 loopback
    loop_en = 1;
    for (int k = 0; k < 16; k++) begin
      tx_data = k[1]; rx_pin = k[0]; tick(1);
    end
    chk(tx_pin == 0, "R2 tx_pin low", tx_pin, 0);
    chk(rx_en && tx_en, "R11 enables in loopback", {rx_en, tx_en}, 3);
    rx_pin = 0; tx_data = 0;
    // R8: leave loopback, inject activity mid count
    loop_en = 0; tick(1);
    chk(!rx_en && !tx_en, "R3 blocked after loopback", {rx_en, tx_en}, 0);
    tick(EOF_CYC - 10);
    rx_pin = 1; tick(1); rx_pin = 0;
    tick(EOF_CYC - 1);
    chk(!rx_en, "R8 restart after activity", rx_en, 0);
    tick(1);
    chk(rx_en, "R8 met after fresh idle", rx_en, 1);
    tick(IFS_CYC);
    // R5/R9 fast mode thresholds
    speed_write(1);
    chk(rate_sel == 1 && stat_code == 0, "R5 fast select", rate_sel, 1);
    loop_en = 1; tick(2); loop_en = 0;
    tick(EOF_CYC/4);
    chk(rx_en && !tx_en, "R9 rx quarter threshold", {rx_en, tx_en}, 2);
    tick(IFS_CYC/4 - EOF_CYC/4);
    chk(tx_en, "R9 tx quarter threshold", tx_en, 1);
    // R9 corner: speed change one sample before normal threshold
    loop_en = 1; speed_write(0); loop_en = 0;
    tick(EOF_CYC - 1);
    fast_wr = 1; fast_wdata = 1; tick(1); fast_wr = 0;
    tick(IFS_CYC);
    // R6 break in fast mode
    brk_det = 1; tick(1); brk_det = 0;
    chk(rate_sel == 0 && stat_code == 8'h1C, "R6 break drops speed", stat_code, 8'h1C);
    // R7 break in normal mode
    brk_det = 1; tick(1); brk_det = 0;
    chk(rate_sel == 0 && stat_code == 8'h1C, "R7 break ignored", stat_code, 8'h1C);
    speed_write(1);
    chk(stat_code == 0, "R5 write clears status", stat_code, 0);
    // R12 collision
    brk_det = 1; fast_wr = 1; fast_wdata = 1; tick(1);
    brk_det = 0; fast_wr = 0;
    chk(rate_sel == 0 && stat_code == 8'h1C, "R12 break wins", {rate_sel, stat_code}, 8'h1C);
    // random traffic
    for (int k = 0; k < 3000; k++) begin
      loop_en    = ($urandom_range(0, 199) == 0) ? ~loop_en : loop_en;
      rx_pin     = ($urandom_range(0, 29) == 0);
      tx_data    = $urandom_range(0, 1);
      brk_det    = ($urandom_range(0, 49) == 0);
      fast_wr    = ($urandom_range(0, 39) == 0);
      fast_wdata = $urandom_range(0, 1);
      tick(1);
    end
    brk_det = 0; fast_wr = 0;
    tick(2);
    finish_run();
  end

endmodule